// File: doc/BRIEF.md
# Three-State Kick Watchdog with Selectable Timeout

This block supervises software activity by watching a kick signal that can be driven low, driven high, or left at a mid/floating level. It advances only on cycles where a timebase tick is present. Each change of the kick between low and high restarts the count. If the kick holds one level for the selected number of ticks, the block issues a one-clock timeout request and pulls its active-low status output low. The status output stays low until the next low/high transition. A mid-level kick switches the watchdog off.

Two periods are available: a long one and a short one. A select input chooses between them. After any reset, the first period is always the long one, whatever the select says. A low-supply flag forces the status output high. A system-reset indication holds the count cleared. The three-level analog sensing and the timebase oscillator are outside this block. The kick arrives already digitised as a two-bit state.

Top module: `kick_watchdog`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `wd_stat_n` is 1 and `wd_req` is 0. Reset also arms the long period.
- R2: The kick encoding is 2'b00 low, 2'b01 high, and 2'b10 or 2'b11 mid. Any tick whose kick differs from the kick at the previous tick restarts the count. A level therefore survives `SHORT_TICKS` ticks, counting the restart tick, and a toggle on the next tick prevents any request.
- R3: A level held for `limit` ticks after its restart tick raises `wd_req` for exactly one clock, after the `limit`-th tick. `wd_stat_n` goes low in that same cycle unless `low_supply` is high.
- R4: The count reloads when it fires. A stuck kick therefore requests again every `limit` ticks.
- R5: A low-to-high or high-to-low kick transition on a tick returns `wd_stat_n` to 1 on the next clock.
- R6: A mid kick clears the count, produces no request and keeps `wd_stat_n` at 1. Leaving mid for low or high starts a fresh count.
- R7: Whenever `low_supply` is high, `wd_stat_n` is 1 on the next clock. This holds even if a timeout fires.
- R8: After `rst` or `sys_rst`, the first period is `LONG_TICKS` even when `short_sel` is 1. Later periods are `SHORT_TICKS` when `short_sel` is 1 and `LONG_TICKS` when it is 0. The first firing or toggle ends the forced-long state.
- R9: While `sys_rst` is high, the count is held at zero and no request is made.
- R10: On clocks without `tick`, the count and the outputs do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high block reset |
| tick | input | 1 | Timebase enable; one count per tick |
| kick_state | input | 2 | Digitised kick: 00 low, 01 high, 1x mid |
| short_sel | input | 1 | 1 selects the short period, 0 the long one |
| low_supply | input | 1 | Low-supply flag; forces status high |
| sys_rst | input | 1 | System-reset indication; clears the count and rearms the long period |
| wd_stat_n | output | 1 | Active-low watchdog status, latched until the next kick edge |
| wd_req | output | 1 | One-clock timeout request pulse |

## Verification
The bench uses a small configuration of 16 and 4 ticks and measures, tick by tick, when each request arrives. The corner cases are these:
- The forced-long first period after both reset kinds. A design that skipped it would fire at 4 instead of 16 ticks.
- The exact boundary between a four-tick hold and a five-tick hold. An off-by-one counter would fire early or never.
- Periodic re-firing on a stuck kick.
- Mid level and 2'b11 both disabling the watchdog.
- The low-supply override, checked while a timeout fires.
- Idle clocks without a tick, which a design ignoring the enable would count toward the limit.

// File: rtl/kick_wd_pkg.sv
package kick_wd_pkg;
  typedef enum logic [1:0] {
    KICK_LOW  = 2'b00,
    KICK_HIGH = 2'b01,
    KICK_MID  = 2'b10
  } kick_e;

  // 2'b11 is folded onto mid: only the two driven codes count as levels
  function automatic kick_e kick_norm(input logic [1:0] raw);
    case (raw)
      2'b00:   return KICK_LOW;
      2'b01:   return KICK_HIGH;
      default: return KICK_MID;
    endcase
  endfunction
endpackage

// File: rtl/kick_sampler.sv
module kick_sampler
  import kick_wd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [1:0] kick_raw,
  output logic       active,
  output logic       change,
  output logic       toggle
);
  kick_e prev_q;
  kick_e cur;

  always_comb begin
    cur    = kick_norm(kick_raw);
    active = (cur != KICK_MID);
    change = tick && (cur != prev_q);
    toggle = change && (cur != KICK_MID) && (prev_q != KICK_MID);
  end

  always_ff @(posedge clk) begin
    if (rst)       prev_q <= KICK_MID;
    else if (tick) prev_q <= cur;
  end

  // R2: a toggle can only be reported on a tick with a driven level
  toggle_level_chk: assert property (@(posedge clk) disable iff (rst)
    toggle |-> (tick && active));
endmodule

// File: rtl/period_select.sv
module period_select #(
  parameter int LONG_TICKS  = 4096,
  parameter int SHORT_TICKS = 1024,
  localparam int CW = $clog2(LONG_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sys_rst,
  input  logic          fire,
  input  logic          toggle,
  input  logic          short_sel,
  output logic [CW-1:0] limit_m1
);
  localparam logic [CW-1:0] LONG_M1  = CW'(LONG_TICKS - 1);
  localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_TICKS - 1);

  logic force_long_q;

  always_ff @(posedge clk) begin
    if (rst || sys_rst)      force_long_q <= 1'b1;
    else if (fire || toggle) force_long_q <= 1'b0;
  end

  assign limit_m1 = (force_long_q || !short_sel) ? LONG_M1 : SHORT_M1;

  // R8: any reset leaves the long period armed on the following cycle
  long_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
    sys_rst |=> (limit_m1 == LONG_M1));
endmodule

// File: rtl/wd_counter.sv
module wd_counter #(
  parameter int LONG_TICKS = 4096,
  localparam int CW = $clog2(LONG_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sys_rst,
  input  logic          tick,
  input  logic          active,
  input  logic          change,
  input  logic [CW-1:0] limit_m1,
  output logic          fire
);
  logic [CW-1:0] cnt_q;

  assign fire = tick && active && !change && !sys_rst && (cnt_q >= limit_m1);

  always_ff @(posedge clk) begin
    if (rst || sys_rst)                 cnt_q <= '0;
    else if (tick) begin
      if (!active || change || fire)    cnt_q <= '0;
      else                              cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(LONG_TICKS));
  // R6
  mid_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !active) |=> (cnt_q == '0));
  // R9
  sysrst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sys_rst |=> (cnt_q == '0));
  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !sys_rst) |=> $stable(cnt_q));
endmodule

// File: rtl/kick_watchdog.sv
module kick_watchdog #(
  parameter int LONG_TICKS  = 4096,
  parameter int SHORT_TICKS = 1024,
  localparam int CW = $clog2(LONG_TICKS + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [1:0] kick_state,
  input  logic       short_sel,
  input  logic       low_supply,
  input  logic       sys_rst,
  output logic       wd_stat_n,
  output logic       wd_req
);
  logic          active, change, toggle, fire;
  logic [CW-1:0] limit_m1;

  kick_sampler u_samp (
    .clk(clk), .rst(rst), .tick(tick), .kick_raw(kick_state),
    .active(active), .change(change), .toggle(toggle)
  );

  period_select #(.LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)) u_per (
    .clk(clk), .rst(rst), .sys_rst(sys_rst), .fire(fire), .toggle(toggle),
    .short_sel(short_sel), .limit_m1(limit_m1)
  );

  wd_counter #(.LONG_TICKS(LONG_TICKS)) u_cnt (
    .clk(clk), .rst(rst), .sys_rst(sys_rst), .tick(tick), .active(active),
    .change(change), .limit_m1(limit_m1), .fire(fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_stat_n <= 1'b1;
      wd_req    <= 1'b0;
    end else begin
      wd_req <= fire;
      if (low_supply)            wd_stat_n <= 1'b1;
      else if (tick && !active)  wd_stat_n <= 1'b1;
      else if (fire)             wd_stat_n <= 1'b0;
      else if (toggle)           wd_stat_n <= 1'b1;
    end
  end

  // R3
  req_single_chk: assert property (@(posedge clk) disable iff (rst)
    wd_req |=> !wd_req);
  // R3
  fire_status_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !low_supply) |=> (!wd_stat_n && wd_req));
  // R5
  edge_release_chk: assert property (@(posedge clk) disable iff (rst)
    toggle |=> wd_stat_n);
  // R7
  low_supply_chk: assert property (@(posedge clk) disable iff (rst)
    low_supply |=> wd_stat_n);
endmodule

// File: tb/test_kick_watchdog.sv
module test_kick_watchdog;
  localparam int LT = 16;
  localparam int ST = 4;
  localparam logic [1:0] LO = 2'b00, HI = 2'b01, MID = 2'b10, MID3 = 2'b11;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, short_sel = 1'b1;
  logic low_supply = 1'b0, sys_rst = 1'b0;
  logic [1:0] kick = MID;
  logic wd_stat_n, wd_req;
  int checks = 0, errors = 0, cycles = 0;
  int n;
  logic req_seen;

  always #2.5 clk = ~clk;

  kick_watchdog #(.LONG_TICKS(LT), .SHORT_TICKS(ST)) i_kick_watchdog (
    .clk(clk), .rst(rst), .tick(tick), .kick_state(kick), .short_sel(short_sel),
    .low_supply(low_supply), .sys_rst(sys_rst), .wd_stat_n(wd_stat_n), .wd_req(wd_req)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one tick with the given kick; req_seen holds the request after that tick
  task automatic do_tick(input logic [1:0] k);
    @(negedge clk); kick = k; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    req_seen = wd_req;
  endtask

  // ticks until a request, 1-based; 0 if none within maxn
  task automatic run_until(input logic [1:0] k, input int maxn, output int cnt);
    cnt = 0;
    for (int i = 1; i <= maxn; i++) begin
      do_tick(k);
      if (req_seen) begin cnt = i; break; end
    end
  endtask

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    check("R1 reset stat", wd_stat_n, 1);
    check("R1 reset req", wd_req, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 stat after reset", wd_stat_n, 1);

    // forced long first period with short selected: restart tick + 16
    run_until(LO, 40, n);
    check("R8 first period long", n, LT + 1);
    check("R3 stat low at timeout", wd_stat_n, 0);
    run_until(LO, 40, n);
    check("R4 periodic short refire", n, ST);
    check("R3 stat stays low", wd_stat_n, 0);

    do_tick(HI);
    check("R5 toggle releases stat", wd_stat_n, 1);
    check("R2 toggle no req", req_seen, 0);
    run_until(HI, 40, n);
    check("R3 short timeout after toggle", n, ST);

    // boundary: a level held SHORT ticks then toggled makes no request
    bad = 0;
    do_tick(LO); if (req_seen) bad++;
    for (int i = 0; i < ST - 1; i++) begin do_tick(LO); if (req_seen) bad++; end
    check("R2 hold of SHORT ticks no req", bad, 0);
    check("R2 stat high during hold", wd_stat_n, 1);
    do_tick(HI); if (req_seen) bad++;
    run_until(HI, 40, n);
    check("R3 hold of SHORT+1 fires on last", n + 1, ST + 1);

    // mid level disables the watchdog
    bad = 0;
    for (int i = 0; i < 40; i++) begin do_tick(MID); if (req_seen || !wd_stat_n) bad++; end
    for (int i = 0; i < 20; i++) begin do_tick(MID3); if (req_seen || !wd_stat_n) bad++; end
    check("R6 mid no req, stat high", bad, 0);
    run_until(LO, 40, n);
    check("R6 fresh count leaving mid", n, ST + 1);

    // low supply forces stat high
    @(negedge clk); low_supply = 1'b1;
    @(negedge clk);
    check("R7 low_supply forces stat", wd_stat_n, 1);
    run_until(LO, 40, n);
    check("R7 req still periodic", n, ST);
    check("R7 stat high through timeout", wd_stat_n, 1);
    @(negedge clk); low_supply = 1'b0;

    // idle clocks without tick do not count
    bad = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (wd_req) bad++; end
    check("R10 no tick no req", bad, 0);
    run_until(LO, 40, n);
    check("R10 count resumes on ticks", n, ST);

    // system reset holds the counter and rearms the long period
    do_tick(LO); do_tick(LO);
    bad = 0;
    @(negedge clk); sys_rst = 1'b1; tick = 1'b1;
    for (int i = 0; i < 3; i++) begin @(negedge clk); if (wd_req) bad++; end
    sys_rst = 1'b0; tick = 1'b0;
    check("R9 no req during sys_rst", bad, 0);
    run_until(LO, 40, n);
    check("R9 count restarted, R8 long after sys_rst", n, LT);

    @(negedge clk); short_sel = 1'b0;
    run_until(LO, 40, n);
    check("R8 long period when not short", n, LT);
    run_until(LO, 40, n);
    check("R4 long periodic refire", n, LT);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule